// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address and a context number into a page table entry. It reads memory one word at a time. A start strobe captures the virtual address, the context number and the current context-table-pointer value. The walker first reads the context's root descriptor from the context table. It then descends through up to three levels of tables. At each level it reads the 2-bit type tag in the low bits of the fetched word, and decides whether to descend, stop with a leaf, or stop with a fault.

When a leaf entry is found, the block returns the raw entry, the level it was found at, and the physical address it maps. The physical address is built from the entry's page number and the low bits of the virtual address, so leaves found higher in the tree map larger regions. A walk that meets an invalid tag or an illegal tag reports a fault code and the level at which the walk stopped. The block leaves permission checking, updates to the referenced and modified bits, and result caching to its neighbours.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_o` are low.
- R2: The first read of a walk goes to context-table base + 4 × context. The base is `{ctp_i[31:4], 8'h00}` (the pointer with its low nibble cleared, shifted left by 4).
- R3: The index at each table level comes from the virtual address, and the read goes to table base + 4 × index. Level 1 uses VA[31:24], level 2 uses VA[23:18], and level 3 uses VA[17:12].
- R4: When the fetched word has tag bits [1:0] = 1 (descriptor) at levels 0 to 2, the walk continues. The next table base is `{entry[31:4], 8'h00}`.
- R5: When a word with tag 2 (page entry) is found at level 1, 2 or 3, the walk ends with `fault_code_o` = 0, `level_o` = that level, and `entry_o` = the word. `paddr_o` is then `{entry[31:20], VA[23:0]}` at level 1, `{entry[31:14], VA[17:0]}` at level 2, or `{entry[31:8], VA[11:0]}` at level 3.
- R6: Tag 0 at any level (0 to 3) ends the walk with `fault_code_o` = 1 and `level_o` = the level that was read.
- R7: Any of the following ends the walk with `fault_code_o` = 2 and `level_o` = that level: tag 3 at any level, tag 2 in the context table (level 0), or tag 1 at level 3.
- R8: A walk makes at most four reads. `mem_req_o` and `mem_addr_o` stay steady until `mem_ack_i` is sampled high.
- R9: `done_o` pulses for one cycle, exactly one cycle after the final acknowledged read. `busy_o` is high from the cycle after an accepted start until `done_o` rises. The result outputs hold until the next `done_o`.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The walk in progress completes with the address and context that were captured at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| vaddr_i | input | 32 | Virtual address to translate |
| ctx_i | input | 16 | Context number |
| ctp_i | input | 32 | Context-table-pointer register value |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 36 | Physical byte address of the requested word |
| mem_ack_i | input | 1 | Read data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle result strobe |
| fault_code_o | output | 2 | 0 none, 1 invalid entry, 2 translation error |
| level_o | output | 2 | Level at which the walk stopped (0 = context table) |
| entry_o | output | 32 | Last word fetched |
| paddr_o | output | 36 | Translated physical address (valid when no fault) |

## Verification
The first request appears the cycle after `start_i` is sampled. Each later request appears the cycle after the previous acknowledge. `done_o` and the result outputs change at the edge that samples the final acknowledge, so they are due exactly one cycle after it. The bench's memory model stamps the cycle of every acknowledge it gives and counts the reads. It then compares the cycle in which `done_o` is seen against the stamp plus one, and reads the results on the falling edge of that cycle and once more a cycle later. Acknowledge delays are random, so the rule is checked under many gap patterns.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    TAG_INV = 2'd0,
    TAG_PTD = 2'd1,
    TAG_PTE = 2'd2,
    TAG_SPC = 2'd3
  } tag_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_XLATE   = 2'd2
  } flt_e;

  typedef enum logic [1:0] {
    ACT_NEXT,
    ACT_LEAF,
    ACT_INV,
    ACT_ERR
  } act_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int CTX_W = 16,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6,
  parameter int PG_W  = 12,
  parameter int PA_W  = 36,
  localparam int HI_W = L1_W + L2_W + L3_W
) (
  input  logic [1:0]       lvl_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [HI_W-1:0]  va_hi_i,
  input  logic [CTX_W-1:0] ctx_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [PA_W-1:0] idx;

  always_comb begin
    unique case (lvl_i)
      2'd0:    idx = PA_W'(ctx_i);
      2'd1:    idx = PA_W'(va_hi_i[HI_W-1 -: L1_W]);
      2'd2:    idx = PA_W'(va_hi_i[L3_W +: L2_W]);
      default: idx = PA_W'(va_hi_i[L3_W-1:0]);
    endcase
    addr_o = base_i + (idx << 2);
  end
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
  import ptw_pkg::*;
#(
  parameter int ENT_W = 32,
  localparam int PA_W = ENT_W + 4
) (
  input  logic [1:0]       lvl_i,
  input  logic [1:0]       tag_i,
  input  logic [ENT_W-5:0] ptr_i,
  output act_e             act_o,
  output logic [PA_W-1:0]  nxt_base_o
);
  assign nxt_base_o = {ptr_i, 8'h00};

  always_comb begin
    unique case (tag_e'(tag_i))
      TAG_INV: act_o = ACT_INV;
      TAG_PTD: act_o = (lvl_i == 2'd3) ? ACT_ERR : ACT_NEXT;
      TAG_PTE: act_o = (lvl_i == 2'd0) ? ACT_ERR : ACT_LEAF;
      default: act_o = ACT_ERR;
    endcase
  end
endmodule

// File: rtl/ptw_leaf_pa.sv
module ptw_leaf_pa #(
  parameter int L2_W  = 6,
  parameter int L3_W  = 6,
  parameter int PG_W  = 12,
  parameter int PPN_W = 24,
  parameter int VA_W  = 32,
  parameter int PA_W  = 36
) (
  input  logic [1:0]       lvl_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [VA_W-1:0]  va_i,
  output logic [PA_W-1:0]  pa_o
);
  localparam int OFF1 = PG_W + L3_W + L2_W;
  localparam int OFF2 = PG_W + L3_W;
  localparam int OFF3 = PG_W;

  logic [PA_W-1:0] mask;
  logic [PA_W-1:0] page;

  always_comb begin
    unique case (lvl_i)
      2'd1:    mask = (PA_W'(1) << OFF1) - PA_W'(1);
      2'd2:    mask = (PA_W'(1) << OFF2) - PA_W'(1);
      2'd3:    mask = (PA_W'(1) << OFF3) - PA_W'(1);
      default: mask = '0;
    endcase
    page = PA_W'({ppn_i, {PG_W{1'b0}}});
    pa_o = (page & ~mask) | (PA_W'(va_i) & mask);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W = 16,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6,
  parameter int PG_W  = 12,
  parameter int ENT_W = 32,
  localparam int VA_W = L1_W + L2_W + L3_W + PG_W,
  localparam int PA_W = ENT_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [ENT_W-1:0] ctp_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [ENT_W-1:0] mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       fault_code_o,
  output logic [1:0]       level_o,
  output logic [ENT_W-1:0] entry_o,
  output logic [PA_W-1:0]  paddr_o
);
  logic             walk_q;
  logic [1:0]       lvl_q;
  logic [PA_W-1:0]  base_q;
  logic [VA_W-1:0]  va_q;
  logic [CTX_W-1:0] ctx_q;
  act_e             act;
  logic [PA_W-1:0]  nxt_base;
  logic [PA_W-1:0]  leaf_pa;

  ptw_addr_gen #(
    .CTX_W(CTX_W), .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W), .PG_W(PG_W), .PA_W(PA_W)
  ) u_addr (
    .lvl_i   (lvl_q),
    .base_i  (base_q),
    .va_hi_i (va_q[VA_W-1:PG_W]),
    .ctx_i   (ctx_q),
    .addr_o  (mem_addr_o)
  );

  ptw_entry_dec #(.ENT_W(ENT_W)) u_dec (
    .lvl_i      (lvl_q),
    .tag_i      (mem_rdata_i[1:0]),
    .ptr_i      (mem_rdata_i[ENT_W-1:4]),
    .act_o      (act),
    .nxt_base_o (nxt_base)
  );

  ptw_leaf_pa #(
    .L2_W(L2_W), .L3_W(L3_W), .PG_W(PG_W), .PPN_W(ENT_W-8), .VA_W(VA_W), .PA_W(PA_W)
  ) u_pa (
    .lvl_i (lvl_q),
    .ppn_i (mem_rdata_i[ENT_W-1:8]),
    .va_i  (va_q),
    .pa_o  (leaf_pa)
  );

  assign mem_req_o = walk_q;
  assign busy_o    = walk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      walk_q       <= 1'b0;
      lvl_q        <= '0;
      base_q       <= '0;
      va_q         <= '0;
      ctx_q        <= '0;
      done_o       <= 1'b0;
      fault_code_o <= FLT_NONE;
      level_o      <= '0;
      entry_o      <= '0;
      paddr_o      <= '0;
    end else begin
      done_o <= 1'b0;
      if (!walk_q) begin
        if (start_i) begin
          walk_q <= 1'b1;
          lvl_q  <= '0;
          base_q <= {ctp_i[ENT_W-1:4], 8'h00};
          va_q   <= vaddr_i;
          ctx_q  <= ctx_i;
        end
      end else if (mem_ack_i) begin
        if (act == ACT_NEXT) begin
          base_q <= nxt_base;
          lvl_q  <= lvl_q + 2'd1;
        end else begin
          walk_q  <= 1'b0;
          done_o  <= 1'b1;
          level_o <= lvl_q;
          entry_o <= mem_rdata_i;
          unique case (act)
            ACT_LEAF: begin
              fault_code_o <= FLT_NONE;
              paddr_o      <= leaf_pa;
            end
            ACT_INV: begin
              fault_code_o <= FLT_INVALID;
              paddr_o      <= '0;
            end
            default: begin
              fault_code_o <= FLT_XLATE;
              paddr_o      <= '0;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int VA_W  = 32,
  parameter int CTX_W = 16,
  parameter int ENT_W = 32,
  parameter int PA_W  = 36
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [VA_W-1:0]  vaddr_i,
  input logic [CTX_W-1:0] ctx_i,
  input logic [ENT_W-1:0] ctp_i,
  input logic             mem_req_o,
  input logic [PA_W-1:0]  mem_addr_o,
  input logic             mem_ack_i,
  input logic [ENT_W-1:0] mem_rdata_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [1:0]       fault_code_o,
  input logic [1:0]       level_o,
  input logic [ENT_W-1:0] entry_o,
  input logic [PA_W-1:0]  paddr_o
);
  logic [2:0] rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_cnt <= '0;
    else if (start_i && !busy_o) rd_cnt <= '0;
    else if (mem_req_o && mem_ack_i) rd_cnt <= rd_cnt + 3'd1;
  end

  AST_READ_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt <= 3'd4); // R8
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> $stable(mem_addr_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !mem_req_o); // R9
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(entry_o) |-> done_o); // R9
  AST_LEAF_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_code_o == 2'd0 |-> level_o != 2'd0); // R5
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fault_code_o != 2'd3); // R7
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic [15:0] ctx_i = '0;
  logic [31:0] ctp_i = '0;
  logic        mem_req_o;
  logic [35:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        busy_o, done_o;
  logic [1:0]  fault_code_o, level_o;
  logic [31:0] entry_o;
  logic [35:0] paddr_o;

  ptw_walker u_ptw_walker (.*);

  always #5 clk_i = ~clk_i;

  int unsigned errors = 0, checks = 0;
  int unsigned cyc = 0, ack_cyc = 0, n_rd = 0;
  logic [35:0] first_addr;
  logic [31:0] mem [logic [35:0]];

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [31:0] rd(input logic [35:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory: random acknowledge delay, data read from the sparse model
  always @(negedge clk_i) begin
    if (mem_req_o && ($urandom_range(0, 2) != 0)) begin
      mem_ack_i = 1'b1;
      mem_rdata_i = rd(mem_addr_o);
      if (n_rd == 0) first_addr = mem_addr_o;
      n_rd++;
      ack_cyc = cyc;
    end else begin
      mem_ack_i = 1'b0;
      mem_rdata_i = $urandom;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] idx(input int l, input logic [15:0] c, input logic [31:0] va);
    case (l)
      0: return 36'(c);
      1: return 36'(va[31:24]);
      2: return 36'(va[23:18]);
      default: return 36'(va[17:12]);
    endcase
  endfunction

  task automatic build(input logic [31:0] ctp, input logic [15:0] c, input logic [31:0] va,
                       input int stop_lvl, input logic [1:0] stop_tag);
    logic [35:0] base = {ctp[31:4], 8'h00};
    mem.delete();
    for (int l = 0; l <= stop_lvl; l++) begin
      logic [31:0] r = $urandom;
      logic [35:0] a = base + (idx(l, c, va) << 2);
      if (l < stop_lvl) begin
        mem[a] = {r[31:2], 2'b01};
        base = {r[31:4], 8'h00};
      end else mem[a] = {r[31:2], stop_tag};
    end
  endtask

  // reference walk from the requirements
  task automatic model(input logic [31:0] ctp, input logic [15:0] c, input logic [31:0] va,
                       output logic [1:0] code, output logic [1:0] lvl, output logic [31:0] e,
                       output logic [35:0] pa, output int nr);
    logic [35:0] base = {ctp[31:4], 8'h00};
    code = 0; lvl = 0; e = 0; pa = 0; nr = 0;
    for (int l = 0; l < 4; l++) begin
      e = rd(base + (idx(l, c, va) << 2));
      nr++;
      lvl = 2'(l);
      if (e[1:0] == 2'd0) begin code = 1; return; end
      if (e[1:0] == 2'd3) begin code = 2; return; end
      if (e[1:0] == 2'd2) begin
        if (l == 0) begin code = 2; return; end
        case (l)
          1: pa = {e[31:20], va[23:0]};
          2: pa = {e[31:14], va[17:0]};
          default: pa = {e[31:8], va[11:0]};
        endcase
        return;
      end
      if (l == 3) begin code = 2; return; end
      base = {e[31:4], 8'h00};
    end
  endtask

  task automatic walk(input logic [31:0] ctp, input logic [15:0] c, input logic [31:0] va,
                      input bit poke);
    logic [1:0] ecode, elvl;
    logic [31:0] eent;
    logic [35:0] epa;
    int enr, t;
    model(ctp, c, va, ecode, elvl, eent, epa, enr);
    @(negedge clk_i);
    n_rd = 0;
    ctp_i = ctp; ctx_i = c; vaddr_i = va; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      vaddr_i = ~va; ctx_i = ~c; start_i = 1'b1;   // R10: must be ignored
      @(negedge clk_i);
      start_i = 1'b0;
    end
    t = 0;
    while (!done_o && t < 200) begin @(negedge clk_i); t++; end
    chk("R6 R7 code", 64'(fault_code_o), 64'(ecode));
    chk("R6 R7 level", 64'(level_o), 64'(elvl));
    chk("R3 R4 entry", 64'(entry_o), 64'(eent));
    if (ecode == 0) chk(poke ? "R10 paddr" : "R5 paddr", 64'(paddr_o), epa);
    chk("R8 reads", 64'(n_rd), 64'(enr));
    chk("R9 done latency", 64'(cyc), 64'(ack_cyc + 1));
    chk("R2 first address", 64'(first_addr), 64'({ctp[31:4], 8'h00} + (36'(c) << 2)));
    @(negedge clk_i);
    chk("R9 pulse", 64'(done_o), 64'(0));
    chk("R9 hold", 64'(entry_o), 64'(eent));
  endtask

  initial begin
    void'($urandom(32'h1234_5a5a));
    repeat (3) @(negedge clk_i);
    chk("R1 busy", 64'(busy_o), 0);
    chk("R1 done", 64'(done_o), 0);
    chk("R1 req", 64'(mem_req_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 req after release", 64'(mem_req_o), 0);
    // directed: leaves per level, invalid per level, illegal tags
    for (int k = 0; k < 11; k++) begin
      int lv[11] = '{1, 2, 3, 0, 1, 2, 3, 2, 0, 3, 3};
      logic [1:0] tg[11] = '{2, 2, 2, 0, 0, 0, 0, 3, 2, 1, 2};
      logic [31:0] ctp = $urandom, va = $urandom;
      logic [15:0] c = 16'($urandom);
      if (k == 0) c = 16'hFFFF;
      build(ctp, c, va, lv[k], tg[k]);
      walk(ctp, c, va, k == 10);
    end
    for (int k = 0; k < 150; k++) begin
      logic [31:0] ctp = $urandom, va = $urandom;
      logic [15:0] c = 16'($urandom);
      build(ctp, c, va, $urandom_range(0, 3), 2'($urandom_range(0, 3)));
      walk(ctp, c, va, ($urandom_range(0, 7) == 0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(10 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule